// File: doc/BRIEF.md
# Modulus-Assisted DDS Phase Generator

This block produces the phase word for a direct digital synthesizer whose frequency steps must be finer than one count of a 32-bit tuning word. A static tuning word sets the coarse rate: software picks the largest word whose frequency does not exceed the target. A second, fractional accumulator is programmed with a numerator A and a modulus B. Each cycle it adds A, and it wraps modulo B. Every wrap adds one extra count to the main phase accumulator. The mean phase increment per clock is therefore FTW + A/B. The tuning word itself is never changed. The extra counts only ever advance the phase.

A 16-bit phase offset is added at the top of the phase word. The sum is then cut down to its 17 most significant bits, which is the width a downstream phase-to-amplitude converter expects, and registered. The five settings are taken together on a single update strobe: tuning word, numerator, modulus, offset and mode enable. The strobe also clears the fractional accumulator. The main accumulator keeps running across updates, so the phase stays continuous.

Top module: `pm_dds_phase`

## Requirements
- R1: While rst_ni is low, and right after it rises, phase_o is 0. Reset clears both accumulators and all captured settings.
- R2: Changes on ftw_i, num_i, mod_i, ofs_i or frac_en_i have no effect on phase_o unless upd_i is high at a rising clock edge.
- R3: At an edge where upd_i is high, all five settings are captured together and the fractional accumulator is cleared. On that same edge the main accumulator still advances using the settings held before the update.
- R4: With fractional mode off, the main accumulator advances by exactly the captured tuning word on every clock, modulo 2^32.
- R5: With fractional mode on, the main accumulator n clocks after the update edge equals (P + n*FTW + floor(n*A/B)) mod 2^32, where P is its value just after the update edge.
- R6: The per-clock increment of the main accumulator is always either the captured tuning word or that word plus one. Extra counts are never negative and never more than one per clock.
- R7: A captured configuration with B < 2 or A >= B behaves exactly as fractional mode off, even when frac_en_i was high.
- R8: The 16-bit offset is added at bits 31:16 of the 32-bit phase, and the addition wraps modulo 2^32.
- R9: phase_o equals bits 31:15 of (accumulator + offset) as they stood before the previous clock edge. This gives one register of latency after the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Capture strobe for all settings |
| ftw_i | input | 32 | Static frequency tuning word |
| num_i | input | 32 | Fraction numerator A |
| mod_i | input | 32 | Fraction modulus B |
| ofs_i | input | 16 | Phase offset, aligned to the top of the phase |
| frac_en_i | input | 1 | Fractional mode request |
| phase_o | output | 17 | Truncated, offset phase word |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator, a 17-bit output, a 16-bit offset and a 32-bit modulus. It uses tuning words near 0x7FFF and 0x8000, where one output count is only a little more than one tuning step. At those rates each injected count decides whether the lowest output bit steps, so R5 and R6 can be read directly at the port. A modulus close to 2^32 drives the full width of the wrap compare. A tuning word of all ones, together with a full-scale offset, reaches the modulo wrap of both additions.

// File: rtl/pm_dds_pkg.sv
package pm_dds_pkg;
  localparam int unsigned DEF_ACC_W = 32;
  localparam int unsigned DEF_OUT_W = 17;
  localparam int unsigned DEF_OFS_W = 16;
  localparam int unsigned DEF_MOD_W = 32;

  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } pm_mode_e;
endpackage

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
  import pm_dds_pkg::*;
#(
  parameter int unsigned ACC_W = DEF_ACC_W,
  parameter int unsigned OFS_W = DEF_OFS_W,
  parameter int unsigned MOD_W = DEF_MOD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [MOD_W-1:0] num_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             frac_en_i,
  output logic [ACC_W-1:0] ftw_o,
  output logic [MOD_W-1:0] num_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [OFS_W-1:0] ofs_o,
  output pm_mode_e         mode_o
);
  localparam logic [MOD_W-1:0] MIN_MOD = MOD_W'(2);

  logic cfg_ok;
  // invalid fraction falls back to integer stepping
  assign cfg_ok = frac_en_i && (mod_i >= MIN_MOD) && (num_i < mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o  <= '0;
      num_o  <= '0;
      mod_o  <= '0;
      ofs_o  <= '0;
      mode_o <= MODE_INT;
    end else if (upd_i) begin
      ftw_o  <= ftw_i;
      num_o  <= num_i;
      mod_o  <= mod_i;
      ofs_o  <= ofs_i;
      mode_o <= cfg_ok ? MODE_FRAC : MODE_INT;
    end
  end

  AST_FRAC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_FRAC) |-> (mod_o >= MIN_MOD) && (num_o < mod_o)); // R7
endmodule

// File: rtl/pm_frac_acc.sv
module pm_frac_acc
  import pm_dds_pkg::*;
#(
  parameter int unsigned MOD_W = DEF_MOD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  pm_mode_e         mode_i,
  input  logic [MOD_W-1:0] num_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             carry_o
);
  localparam int unsigned SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] aux_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_wrap;
  logic             wrap;

  assign sum      = {1'b0, aux_q} + {1'b0, num_i};
  assign wrap     = sum >= {1'b0, mod_i};
  assign sum_wrap = sum - {1'b0, mod_i};
  assign carry_o  = (mode_i == MODE_FRAC) && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_q <= '0;
    end else if (clr_i || mode_i != MODE_FRAC) begin
      aux_q <= '0;
    end else if (wrap) begin
      aux_q <= sum_wrap[MOD_W-1:0];
    end else begin
      aux_q <= sum[MOD_W-1:0];
    end
  end

  AST_AUX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> aux_q == '0); // R3
  AST_AUX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FRAC) |-> aux_q < mod_i); // R5
endmodule

// File: rtl/pm_phase_acc.sv
module pm_phase_acc #(
  parameter int unsigned ACC_W = pm_dds_pkg::DEF_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic             carry_i,
  output logic [ACC_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else         acc_o <= acc_o + ftw_i + ACC_W'(carry_i);
  end
endmodule

// File: rtl/pm_phase_trunc.sv
module pm_phase_trunc #(
  parameter int unsigned ACC_W = pm_dds_pkg::DEF_ACC_W,
  parameter int unsigned OUT_W = pm_dds_pkg::DEF_OUT_W,
  parameter int unsigned OFS_W = pm_dds_pkg::DEF_OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OUT_W-1:0] phase_o
);
  localparam int unsigned PAD_W = ACC_W - OFS_W;

  logic [ACC_W-1:0] sum;
  assign sum = acc_i + {ofs_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= sum[ACC_W-1 -: OUT_W];
  end
endmodule

// File: rtl/pm_dds_phase.sv
module pm_dds_phase
  import pm_dds_pkg::*;
#(
  parameter int unsigned ACC_W = DEF_ACC_W,
  parameter int unsigned OUT_W = DEF_OUT_W,
  parameter int unsigned OFS_W = DEF_OFS_W,
  parameter int unsigned MOD_W = DEF_MOD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [MOD_W-1:0] num_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             frac_en_i,
  output logic [OUT_W-1:0] phase_o
);
  logic [ACC_W-1:0] ftw_q;
  logic [MOD_W-1:0] num_q;
  logic [MOD_W-1:0] mod_q;
  logic [OFS_W-1:0] ofs_q;
  pm_mode_e         mode_q;
  logic             carry;
  logic [ACC_W-1:0] acc_q;

  pm_cfg_reg #(.ACC_W(ACC_W), .OFS_W(OFS_W), .MOD_W(MOD_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i),
    .ftw_i(ftw_i), .num_i(num_i), .mod_i(mod_i), .ofs_i(ofs_i),
    .frac_en_i(frac_en_i),
    .ftw_o(ftw_q), .num_o(num_q), .mod_o(mod_q), .ofs_o(ofs_q),
    .mode_o(mode_q)
  );

  pm_frac_acc #(.MOD_W(MOD_W)) u_frac (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(upd_i), .mode_i(mode_q),
    .num_i(num_q), .mod_i(mod_q), .carry_o(carry)
  );

  pm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ftw_i(ftw_q), .carry_i(carry),
    .acc_o(acc_q)
  );

  pm_phase_trunc #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OFS_W(OFS_W)) u_trunc (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_q), .ofs_i(ofs_q),
    .phase_o(phase_o)
  );

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (acc_q - $past(acc_q) - $past(ftw_q)) <= ACC_W'(1)); // R6
  AST_INT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_INT) |=> acc_q == $past(acc_q) + $past(ftw_q)); // R4
  AST_OFS0_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_q == '0) |=> phase_o == $past(acc_q[ACC_W-1 -: OUT_W])); // R9
endmodule

// File: tb/pm_dds_phase_test.sv
module pm_dds_phase_test;
  localparam int NV = 8;
  localparam logic [31:0] F_TAB [NV] = '{32'h0000_8000, 32'h1234_5678, 32'h0000_7FFF, 32'hFFFF_FFFF,
                                         32'h0000_7FFF, 32'h0000_7FFF, 32'h4000_0000, 32'h0000_7FFF};
  localparam logic [31:0] A_TAB [NV] = '{32'd0, 32'd1, 32'd1, 32'd7,
                                         32'd5, 32'd0, 32'd999, 32'hFFFF_FFFE};
  localparam logic [31:0] B_TAB [NV] = '{32'd2, 32'd3, 32'd2, 32'd8,
                                         32'd5, 32'd1, 32'd1000, 32'hFFFF_FFFF};
  localparam logic [15:0] O_TAB [NV] = '{16'h0000, 16'h0100, 16'h0000, 16'hFFFF,
                                         16'h0000, 16'h0000, 16'h8000, 16'h1234};
  localparam bit          E_TAB [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int          N_TAB [NV] = '{40, 60, 80, 50, 30, 30, 50, 70};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, upd, en;
  logic [31:0] ftw, num, modv;
  logic [15:0] ofs;
  logic [16:0] phase;

  pm_dds_phase uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .ftw_i(ftw), .num_i(num),
    .mod_i(modv), .ofs_i(ofs), .frac_en_i(en), .phase_o(phase)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  longint unsigned base;
  logic [31:0] cf, ca, cb;
  logic [15:0] cofs;
  bit          cen;
  longint unsigned n;

  function automatic logic [31:0] acc_at(longint unsigned k);
    longint unsigned v;
    v = base + k * longint'(cf);
    if (cen) v = v + (k * longint'(ca)) / longint'(cb);
    return v[31:0];
  endfunction

  function automatic logic [16:0] trunc(logic [31:0] a, logic [15:0] o);
    logic [31:0] s;
    s = a + {o, 16'h0000};
    return s[31:15];
  endfunction

  task automatic check(string req, logic [16:0] exp);
    checks++;
    if (phase !== exp) begin
      errors++;
      $display("FAIL %s phase=%h expected=%h", req, phase, exp);
    end
  endtask

  task automatic model_reset();
    base = 0; cf = '0; ca = '0; cb = '0; cofs = '0; cen = 1'b0; n = 0;
  endtask

  // one clock; inputs already set at a negedge
  task automatic cycle(bit u, string req);
    logic [31:0] prev;
    logic [15:0] pofs;
    prev = acc_at(n);
    pofs = cofs;
    upd  = u;
    @(posedge clk);
    if (u) begin
      base = longint'(acc_at(n + 1));
      cf = ftw; ca = num; cb = modv; cofs = ofs;
      cen = en && (modv >= 32'd2) && (num < modv);
      n = 0;
    end else begin
      n++;
    end
    @(negedge clk);
    upd = 1'b0;
    check(req, trunc(prev, pofs));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", 17'h0);
    rst_n = 1'b1;
    model_reset();
    check("R1 after reset", 17'h0);
  endtask

  function automatic string tag(int i);
    case (i)
      0: return "R4 integer step";
      1: return "R5 thirds";
      2: return "R6 half step";
      3: return "R8 wrap";
      4: return "R7 A>=B";
      5: return "R7 B<2";
      6: return "R5 large B";
      default: return "R5 near-full modulus";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    upd = 1'b0; en = 1'b0; ftw = '0; num = '0; modv = '0; ofs = '0;
    model_reset();
    do_reset();

    // R2: no strobe, inputs ignored
    ftw = 32'h0100_0000; num = 32'd1; modv = 32'd3; ofs = 16'h4000; en = 1'b1;
    for (int k = 0; k < 10; k++) cycle(1'b0, "R2 no strobe");

    // vector table, phase continuous across updates (R3)
    for (int i = 0; i < NV; i++) begin
      ftw = F_TAB[i]; num = A_TAB[i]; modv = B_TAB[i]; ofs = O_TAB[i]; en = E_TAB[i];
      cycle(1'b1, "R3 update edge");
      for (int k = 0; k < N_TAB[i]; k++) cycle(1'b0, tag(i));
    end

    // R2 mid-run: inputs change without strobe
    ftw = 32'hDEAD_BEEF; num = 32'd3; modv = 32'd4; ofs = 16'h7777; en = 1'b0;
    for (int k = 0; k < 20; k++) cycle(1'b0, "R2 mid-run ignore");

    // R9 latency: from reset, first nonzero output one clock after acc moves
    do_reset();
    ftw = 32'h0001_0000; num = '0; modv = 32'd2; ofs = '0; en = 1'b0;
    cycle(1'b1, "R9 update");
    cycle(1'b0, "R9 acc moves, out still old");
    cycle(1'b0, "R9 first step visible");
    if (phase != 17'd2) begin
      errors++; $display("FAIL R9 phase=%h expected=%h", phase, 17'd2);
    end
    checks++;

    // R3: repeated update clears fraction state; A/B=3/4 restarted each time
    ftw = 32'h0000_7FFF; num = 32'd3; modv = 32'd4; ofs = 16'h0001; en = 1'b1;
    for (int r = 0; r < 5; r++) begin
      cycle(1'b1, "R3 re-update");
      for (int k = 0; k < 3; k++) cycle(1'b0, "R3 fraction restart");
    end

    // R1: reset mid-run returns output to zero
    for (int k = 0; k < 5; k++) cycle(1'b0, "R5 before reset");
    do_reset();
    for (int k = 0; k < 5; k++) cycle(1'b0, "R1 settings cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule